// File: doc/BRIEF.md
# Serial Character Receiver with Address Filtering

This block recovers asynchronous serial characters from a single line and queues them in a small receive buffer. It samples the line on a baud tick that runs at sixteen times the bit rate. It supports plain 8-bit characters, 8-bit characters followed by an even or odd parity bit, and 9-bit characters. In 9-bit mode it can be told to keep only characters whose top bit is set. This lets a node on a shared line ignore payload bytes meant for other nodes until its own address arrives.

Each buffered entry carries its own parity-error and framing-error bits. The status outputs therefore always describe the character now presented at the head of the buffer. A pop strobe moves the head to the next entry. When a character finishes while the buffer is full, a sticky overrun flag is raised. New characters are then dropped until software clears the flag with a strobe. That strobe also empties the buffer and restarts the shift engine.

Top module: `sercom_rx`

## Requirements
- R1: After reset, rx_idle is 1 and data_avail, overrun, par_err and frm_err are 0. Whenever the buffer is empty, rx_data, par_err and frm_err read 0.
- R2: With nine_bit=0 and parity_mode 2'b00 or 2'b11, a frame is start bit (0), 8 data bits LSB first, then a stop bit (1). The character appears on rx_data[7:0] with rx_data[8]=0.
- R3: With nine_bit=1, a frame carries 9 data bits LSB first and no parity bit. All 9 bits appear on rx_data. parity_mode is ignored.
- R4: With nine_bit=0, parity_mode 2'b01 selects even parity and 2'b10 selects odd parity. A parity bit follows the 8 data bits, and par_err is 1 for a head character whose data and parity bits do not match the selected parity.
- R5: frm_err is 1 for a head character whose stop bit was sampled low.
- R6: par_err and frm_err describe the head entry only. After a pop, they reflect the next entry on the following cycle.
- R7: With nine_bit=1 and addr_filter=1, a character is stored only when its bit 8 is 1.
- R8: With nine_bit=0, addr_filter has no effect: every character is stored.
- R9: The buffer holds 4 characters in arrival order. data_avail is 1 exactly while at least one character is buffered.
- R10: A character that completes while the buffer is full sets overrun. overrun stays set until cleared by ovf_clear. While overrun is set, new characters are discarded and the buffered ones are kept.
- R11: ovf_clear while overrun is set clears overrun, empties the buffer and returns the receiver to idle. ovf_clear while overrun is 0 has no effect.
- R12: rx_idle goes to 0 when a start bit is detected and returns to 1 once the stop bit has been sampled.
- R13: rd_pop on an empty buffer is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial input line, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| nine_bit | input | 1 | 1 selects 9-bit characters |
| parity_mode | input | 2 | 00 none, 01 even, 10 odd, 11 none (8-bit mode only) |
| addr_filter | input | 1 | Keep only characters with bit 8 set (9-bit mode only) |
| rd_pop | input | 1 | Remove the head character |
| ovf_clear | input | 1 | Clear overrun and flush the receiver |
| rx_data | output | 9 | Head character |
| data_avail | output | 1 | Buffer holds at least one character |
| rx_idle | output | 1 | No character is being shifted in |
| par_err | output | 1 | Parity error of the head character |
| frm_err | output | 1 | Framing error of the head character |
| overrun | output | 1 | Sticky overrun flag |

## Verification
A character reaches the head about two clock cycles after the middle of its stop bit: one cycle for the done pulse and one for the buffer write. The bench therefore checks buffer contents only after a full bit time of idle line following the stop bit, long after that point. Pops and overrun clears take effect at the next rising edge, and their results are sampled at the falling edge that follows. rx_idle is sampled one full bit time after the start edge and again after the idle gap, so neither check sits near a transition.

// File: rtl/sercom_rx_pkg.sv
package sercom_rx_pkg;
  localparam int CHAR_W = 9;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_OFF  = 2'b11
  } parity_e;

  typedef struct packed {
    logic              ferr;
    logic              perr;
    logic [CHAR_W-1:0] word;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/sercom_rx_shifter.sv
module sercom_rx_shifter
  import sercom_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      flush,
  input  logic      baud_tick,
  input  logic      rxd,
  input  logic      nine_bit,
  input  logic [1:0] parity_mode,
  output logic      idle,
  output logic      done,
  output rx_entry_t ent
);
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2 - 1;
  localparam int BW  = $clog2(CHAR_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} state_e;

  state_e            state;
  logic [1:0]        sync;
  logic              rx_s;
  logic [CW-1:0]     tcnt;
  logic [BW-1:0]     bidx;
  logic [CHAR_W-1:0] sh;
  logic              nine_q;
  parity_e           par_q;
  logic              par_on;
  logic              last_bit;
  logic [CHAR_W-1:0] word_c;
  logic              perr_c;

  assign rx_s     = sync[1];
  assign par_on   = !nine_q && (par_q == PAR_EVEN || par_q == PAR_ODD);
  assign last_bit = (bidx == BW'((nine_q || par_on) ? CHAR_W - 1 : CHAR_W - 2));
  assign idle     = (state == ST_IDLE);

  always_comb begin
    if (nine_q)      word_c = sh;
    else if (par_on) word_c = {1'b0, sh[CHAR_W-2:0]};
    else             word_c = {1'b0, sh[CHAR_W-1:1]};
    perr_c = par_on && ((^sh) != (par_q == PAR_ODD));
  end

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      state  <= ST_IDLE;
      tcnt   <= '0;
      bidx   <= '0;
      sh     <= '0;
      done   <= 1'b0;
      ent    <= '0;
      nine_q <= 1'b0;
      par_q  <= PAR_NONE;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (baud_tick && !rx_s) begin
          state  <= ST_START;
          tcnt   <= '0;
          nine_q <= nine_bit;
          par_q  <= parity_e'(parity_mode);
        end
        ST_START: if (baud_tick) begin
          if (tcnt == CW'(MID)) begin
            tcnt  <= '0;
            bidx  <= '0;
            state <= rx_s ? ST_IDLE : ST_DATA;
          end else tcnt <= tcnt + 1'b1;
        end
        ST_DATA: if (baud_tick) begin
          if (tcnt == CW'(OVS - 1)) begin
            tcnt <= '0;
            sh   <= {rx_s, sh[CHAR_W-1:1]};
            bidx <= bidx + 1'b1;
            if (last_bit) state <= ST_STOP;
          end else tcnt <= tcnt + 1'b1;
        end
        ST_STOP: if (baud_tick) begin
          if (tcnt == CW'(OVS - 1)) begin
            state    <= ST_IDLE;
            done     <= 1'b1;
            ent.word <= word_c;
            ent.perr <= perr_c;
            ent.ferr <= !rx_s;
          end else tcnt <= tcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R12: leaving idle needs a low line sample
  assert_idle_start_R12: assert property (@(posedge clk) disable iff (rst)
    $fell(idle) |-> !$past(rx_s));
  // R12: a character completes only out of the stop phase
  assert_done_from_stop_R12: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(state == ST_STOP));
endmodule

// File: rtl/sercom_rx_fifo.sv
module sercom_rx_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] count;
  logic            do_pop;

  assign empty  = (count == '0);
  assign full   = (count == CNTW'(DEPTH));
  assign do_pop = pop && !empty;
  assign dout   = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= nxt(wr_ptr);
      if (do_pop) rd_ptr <= nxt(rd_ptr);
      if (push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !push) count <= count - 1'b1;
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
    count <= CNTW'(DEPTH));
  assert_empty_pop_R13: assert property (@(posedge clk) disable iff (rst)
    (empty && !push && !flush) |=> empty);
endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
  import sercom_rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxd,
  input  logic       baud_tick,
  input  logic       nine_bit,
  input  logic [1:0] parity_mode,
  input  logic       addr_filter,
  input  logic       rd_pop,
  input  logic       ovf_clear,
  output logic [8:0] rx_data,
  output logic       data_avail,
  output logic       rx_idle,
  output logic       par_err,
  output logic       frm_err,
  output logic       overrun
);
  rx_entry_t s_ent, head;
  logic      s_done, flush, keep, push, empty, full;

  assign flush = ovf_clear && overrun;
  assign keep  = s_done && (!(nine_bit && addr_filter) || s_ent.word[CHAR_W-1]);
  assign push  = keep && !overrun && !full && !flush;

  sercom_rx_shifter #(.OVS(OVS)) u_shift (
    .clk(clk), .rst(rst), .flush(flush), .baud_tick(baud_tick), .rxd(rxd),
    .nine_bit(nine_bit), .parity_mode(parity_mode),
    .idle(rx_idle), .done(s_done), .ent(s_ent)
  );

  logic [ENTRY_W-1:0] head_raw;

  sercom_rx_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush), .push(push), .din(s_ent),
    .pop(rd_pop), .dout(head_raw), .empty(empty), .full(full)
  );

  assign head       = empty ? '0 : rx_entry_t'(head_raw);
  assign rx_data    = head.word;
  assign par_err    = head.perr;
  assign frm_err    = head.ferr;
  assign data_avail = !empty;

  always_ff @(posedge clk) begin
    if (rst || flush)                   overrun <= 1'b0;
    else if (keep && !overrun && full)  overrun <= 1'b1;
  end

  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ovf_clear) |=> overrun);
  assert_clear_flushes_R11: assert property (@(posedge clk) disable iff (rst)
    (overrun && ovf_clear) |=> (!data_avail && rx_idle && !overrun));
  assert_addr_only_R7: assert property (@(posedge clk) disable iff (rst)
    (push && nine_bit && addr_filter) |-> s_ent.word[CHAR_W-1]);
endmodule

// File: tb/sercom_rx_test.sv
module sercom_rx_test;
  localparam int BITC = 32;

  logic       clk = 0, rst = 1, rxd = 1, baud_tick = 0;
  logic       nine_bit = 0, addr_filter = 0, rd_pop = 0, ovf_clear = 0;
  logic [1:0] parity_mode = 2'b00;
  logic [8:0] rx_data;
  logic       data_avail, rx_idle, par_err, frm_err, overrun;

  int checks = 0, failures = 0;
  logic [10:0] model[$];

  sercom_rx uut (.*);

  always #2.5 clk = ~clk;
  initial forever begin @(negedge clk); baud_tick = ~baud_tick; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_entry(input int mode, input logic [8:0] d,
                                            input bit bp, input bit bs);
    logic [8:0] w;
    w = (mode == 3) ? d : {1'b0, d[7:0]};
    return {bs, (mode == 1 || mode == 2) && bp, w};
  endfunction

  task automatic check_head(input string req);
    if (model.size() == 0) begin
      chk({req, " empty avail"}, data_avail, 0);
      chk({req, " empty data"}, {frm_err, par_err, rx_data}, 0);
    end else begin
      chk({req, " avail"}, data_avail, 1);
      chk({req, " head"}, {frm_err, par_err, rx_data}, model[0]);
    end
  endtask

  task automatic send_bit(input logic b, input int n);
    rxd = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_char(input int mode, input logic [8:0] d, input bit bp,
                           input bit bs, input bit flt);
    int nb;
    nine_bit    = (mode == 3);
    parity_mode = (mode == 1) ? 2'b01 : (mode == 2) ? 2'b10 : ((mode == 4) ? 2'b11 : 2'b00);
    addr_filter = flt;
    nb = (mode == 3) ? 9 : 8;
    send_bit(0, BITC);
    chk("R12 busy mid-frame", rx_idle, 0);
    for (int i = 0; i < nb; i++) send_bit(d[i], BITC);
    if (mode == 1 || mode == 2) send_bit((^d[7:0]) ^ (mode == 2) ^ bp, BITC);
    if (bs) begin send_bit(0, 24); send_bit(1, 8); end
    else send_bit(1, BITC);
    send_bit(1, 40);
    chk("R12 idle after frame", rx_idle, 1);
    if (mode != 3 || !flt || d[8]) begin
      if (model.size() < 4 && !overrun) model.push_back(exp_entry(mode, d, bp, bs));
    end
  endtask

  task automatic do_pop(input string req);
    @(negedge clk); rd_pop = 1;
    @(negedge clk); rd_pop = 0;
    if (model.size() > 0) void'(model.pop_front());
    check_head(req);
  endtask

  task automatic strobe_clear();
    @(negedge clk); ovf_clear = 1;
    @(negedge clk); ovf_clear = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 idle", rx_idle, 1);
    chk("R1 avail", data_avail, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 flags+data", {frm_err, par_err, rx_data}, 0);

    do_pop("R13 pop on empty");

    send_char(0, 9'h0A5, 0, 0, 0);
    check_head("R2 8-bit char");
    send_char(1, 9'h03C, 0, 0, 0);
    send_char(2, 9'h081, 1, 0, 0);
    check_head("R6 head unchanged by later errors");
    do_pop("R4 even parity ok");
    do_pop("R4 odd parity error");
    chk("R4 par_err set", par_err, 1);
    do_pop("R9 empty after drain");

    send_char(4, 9'h055, 0, 1, 0);
    check_head("R5 framing error");
    chk("R5 frm_err set", frm_err, 1);
    send_char(0, 9'h0C3, 0, 0, 0);
    do_pop("R6 flags follow next entry");
    chk("R6 frm_err clear on next", frm_err, 0);
    do_pop("R9 drain");

    send_char(3, 9'h1F0, 0, 0, 0);
    check_head("R3 nine-bit char");
    do_pop("R3 drain");
    send_char(3, 9'h012, 0, 0, 1);
    check_head("R7 data char dropped");
    send_char(3, 9'h1AB, 0, 0, 1);
    check_head("R7 address char kept");
    do_pop("R7 drain");
    send_char(0, 9'h012, 0, 0, 1);
    check_head("R8 filter ignored in 8-bit");

    strobe_clear();
    check_head("R11 clear without overrun no effect");
    do_pop("R11 drain");

    for (int i = 0; i < 4; i++) send_char(0, 9'(8'h10 + i), 0, 0, 0);
    chk("R9 four held, no overrun", overrun, 0);
    send_char(0, 9'h0EE, 0, 0, 0);
    chk("R10 overrun set", overrun, 1);
    check_head("R10 head kept");
    send_char(0, 9'h0DD, 0, 0, 0);
    do_pop("R10 second entry kept");
    chk("R10 overrun sticky after pop", overrun, 1);
    send_char(0, 9'h0BB, 0, 0, 0);
    check_head("R10 char discarded while overrun");
    strobe_clear();
    model.delete();
    chk("R11 overrun cleared", overrun, 0);
    check_head("R11 flushed");
    chk("R11 idle", rx_idle, 1);
    send_char(0, 9'h077, 0, 0, 0);
    check_head("R11 receives after clear");
    do_pop("R11 drain");

    for (int i = 0; i < 40; i++) begin
      int mode;
      mode = int'($urandom % 5);
      if (model.size() == 4) do_pop("R9 random pop");
      send_char(mode, 9'($urandom % 512), ($urandom % 5) == 0, ($urandom % 6) == 0,
                ($urandom % 2) == 1);
      check_head("R6 random head");
      chk("R10 random no overrun", overrun, 0);
      if ($urandom % 3 == 0) do_pop("R9 random pop");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule